// File: doc/BRIEF.md
# Page-Buffered Flash Command Engine

This block is the device-side command processor of a serial flash memory that has page buffers. A host reaches it over a four-wire SPI-style link: an active-low select, a serial clock, a data input and a data output. Each array command is a framed transfer of one opcode byte and a three-byte address. The engine carries out two array operations against either of two page buffers:

- **Compare:** checks a main-array page against a buffer.
- **Rewrite:** copies a main page into a buffer, then programs the buffer back into the same page.

The main array is a small register model. Its size and the durations of each phase are parameters.

A command is not acted on when its last bit arrives. It is committed by the rising edge of the select line. While an array operation runs, the ready pin is low and the status byte reports busy. Further array commands are ignored until the operation ends. A status read stays usable at all times, and it returns the live status byte for as long as select is held low.

Top module: `pagebuf_cmd_engine`

## Requirements
- R1: After reset, `rdy_o` is 1 and a status read returns 0x80. Status bit 7 is 1 when ready and 0 when busy. Bit 6 holds the last compare result. Bits 5..0 read 0.
- R2: Bits are sampled on SCK rising edges while `cs_ni` is low, MSB first. A frame is one opcode byte followed by a 24-bit address. Address bits 23..11 hold the page number and bits 10..0 are ignored. The array uses the low `$clog2(PAGES)` bits of the page number, so page 19 selects page 3 when PAGES=16.
- R3: An array command starts only on the rising edge of `cs_ni`, and only when exactly 32 bits were clocked in. While `cs_ni` stays low after a complete frame, `rdy_o` stays 1.
- R4: Opcode 0x60 compares the addressed page with buffer 1, and 0x61 compares it with buffer 2. The engine is busy for CMP_CYC clock cycles. At the end, status bit 6 becomes 0 if all bytes match and 1 on any mismatch.
- R5: Opcode 0x58 rewrites the page through buffer 1, and 0x59 rewrites it through buffer 2. The buffer receives the page contents and then the page is programmed from the buffer. The engine is busy for XFER_CYC+PROG_CYC cycles.
- R6: During any array operation, `rdy_o` is 0 and status bit 7 reads 0.
- R7: An array command that completes while the engine is busy is ignored. It does not stretch the busy time, alter any buffer, or change bit 6.
- R8: Opcode 0xD7 shifts the status byte out on `so_o`, MSB first, one bit per SCK falling edge after the opcode. The status is re-sampled at every byte boundary and repeats until `cs_ni` rises. `so_o` is 0 outside a status read.
- R9: Frames with an unknown opcode, or with a bit count other than 32, are ignored.
- R10: Status bit 6 changes only when a compare completes. A rewrite leaves it unchanged.
- R11: After reset, byte b of main page p holds (p*PAGE_BYTES+b+1) mod 256, and both buffers hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select |
| sck_i | input | 1 | Serial clock, much slower than clk_i |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial status data out |
| rdy_o | output | 1 | 1 = ready, 0 = array operation running |

## Verification
The assertions assume these properties of the inputs:
- `sck_i`, `cs_ni` and `si_i` are oversampled by `clk_i` through a short synchronizer, so each SCK level must last at least three system clocks.
- `si_i` is stable before each SCK rise.
- `cs_ni` toggles only while SCK is low.

The stimulus holds every SCK level for six clocks and changes SI and CS only in the low phase. It samples SO just before the next rise. Busy commands are sent early enough in a rewrite that they fully arrive inside its busy window.

// File: rtl/fce_pkg.sv
package fce_pkg;
  localparam logic [7:0] OP_CMP_B1 = 8'h60;
  localparam logic [7:0] OP_CMP_B2 = 8'h61;
  localparam logic [7:0] OP_RW_B1  = 8'h58;
  localparam logic [7:0] OP_RW_B2  = 8'h59;
  localparam logic [7:0] OP_STAT   = 8'hD7;
  localparam int FRAME_BITS = 32;
  localparam int ADDR_BITS  = 24;
  localparam int PA_LSB     = 11;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_CMP,
    ENG_XFER,
    ENG_PROG
  } eng_state_e;
endpackage

// File: rtl/fce_spi_rx.sv
module fce_spi_rx
  import fce_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 sck_i,
  input  logic                 si_i,
  output logic                 sck_fall_o,
  output logic                 op_done_o,
  output logic [7:0]           op_o,
  output logic                 launch_o,
  output logic [ADDR_BITS-1:0] addr_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_OP   = CNT_W'(8);

  logic [2:0] cs_s, sck_s;
  logic [1:0] si_s;
  logic       cs_hi, sck_rise, cs_rise;
  logic [CNT_W-1:0]      bitcnt;
  logic [FRAME_BITS-1:0] shreg;
  logic [7:0]            op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_s  <= 3'b111;
      sck_s <= 3'b000;
      si_s  <= 2'b00;
    end else begin
      cs_s  <= {cs_s[1:0], cs_ni};
      sck_s <= {sck_s[1:0], sck_i};
      si_s  <= {si_s[0], si_i};
    end
  end

  assign cs_hi      = cs_s[1];
  assign cs_rise    = cs_s[1] & ~cs_s[2];
  assign sck_rise   = sck_s[1] & ~sck_s[2];
  assign sck_fall_o = ~sck_s[1] & sck_s[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bitcnt <= '0;
      shreg  <= '0;
      op_q   <= '0;
    end else if (cs_hi) begin
      bitcnt <= '0;
    end else if (sck_rise) begin
      shreg <= {shreg[FRAME_BITS-2:0], si_s[1]};
      if (bitcnt != CNT_OVER) bitcnt <= bitcnt + 1'b1;
      if (bitcnt == CNT_OP - 1'b1) op_q <= {shreg[6:0], si_s[1]};
    end
  end

  // frame committed by select release, exact length only
  assign launch_o  = cs_rise && (bitcnt == CNT_FULL);
  assign addr_o    = shreg[ADDR_BITS-1:0];
  assign op_o      = op_q;
  assign op_done_o = !cs_hi && (bitcnt >= CNT_OP);

  p_cnt_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_hi |=> (bitcnt == '0));
  p_launch_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> cs_hi);
endmodule

// File: rtl/fce_stat_tx.sv
module fce_stat_tx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic       fall_i,
  input  logic [7:0] stat_i,
  output logic       so_o
);
  logic [2:0] pos_q;
  logic [7:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      sh_q  <= '0;
      so_o  <= 1'b0;
    end else if (!active_i) begin
      pos_q <= '0;
      so_o  <= 1'b0;
    end else if (fall_i) begin
      // fresh snapshot at each byte boundary
      if (pos_q == '0) begin
        so_o <= stat_i[7];
        sh_q <= {stat_i[6:0], 1'b0};
      end else begin
        so_o <= sh_q[7];
        sh_q <= {sh_q[6:0], 1'b0};
      end
      pos_q <= pos_q + 1'b1;
    end
  end

  p_so_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !so_o);
  p_so_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !fall_i && $past(active_i)) |=> $stable(so_o));
endmodule

// File: rtl/fce_engine.sv
module fce_engine
  import fce_pkg::*;
#(
  parameter int PAGES      = 16,
  parameter int PAGE_BYTES = 8,
  parameter int CMP_CYC    = 200,
  parameter int XFER_CYC   = 300,
  parameter int PROG_CYC   = 1000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 launch_i,
  input  logic [7:0]           op_i,
  input  logic [ADDR_BITS-1:0] addr_i,
  output logic                 busy_o,
  output logic                 mism_o
);
  localparam int PG_W    = $clog2(PAGES);
  localparam int MAX_CYC = (CMP_CYC > XFER_CYC) ?
                           ((CMP_CYC > PROG_CYC) ? CMP_CYC : PROG_CYC) :
                           ((XFER_CYC > PROG_CYC) ? XFER_CYC : PROG_CYC);
  localparam int TMR_W   = $clog2(MAX_CYC + 1);

  eng_state_e       state;
  logic [TMR_W-1:0] tmr;
  logic [PG_W-1:0]  page_q;
  logic             sel_q, mism_q;
  logic [7:0]       main_q [PAGES][PAGE_BYTES];
  logic [7:0]       pbuf_q [2][PAGE_BYTES];
  logic             is_cmp, is_rw, is_arr, differ;

  assign is_cmp = (op_i == OP_CMP_B1) || (op_i == OP_CMP_B2);
  assign is_rw  = (op_i == OP_RW_B1)  || (op_i == OP_RW_B2);
  assign is_arr = is_cmp || is_rw;

  always_comb begin
    differ = 1'b0;
    for (int b = 0; b < PAGE_BYTES; b++)
      if (main_q[page_q][b] != pbuf_q[sel_q][b]) differ = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state  <= ENG_IDLE;
      tmr    <= '0;
      page_q <= '0;
      sel_q  <= 1'b0;
      mism_q <= 1'b0;
      for (int p = 0; p < PAGES; p++)
        for (int b = 0; b < PAGE_BYTES; b++)
          main_q[p][b] <= 8'(p * PAGE_BYTES + b + 1);
      for (int s = 0; s < 2; s++)
        for (int b = 0; b < PAGE_BYTES; b++)
          pbuf_q[s][b] <= '0;
    end else begin
      unique case (state)
        ENG_IDLE: if (launch_i && is_arr) begin
          page_q <= addr_i[PA_LSB +: PG_W];
          sel_q  <= op_i[0];
          tmr    <= is_cmp ? TMR_W'(CMP_CYC - 1) : TMR_W'(XFER_CYC - 1);
          state  <= is_cmp ? ENG_CMP : ENG_XFER;
        end
        ENG_CMP: if (tmr == '0) begin
          mism_q <= differ;
          state  <= ENG_IDLE;
        end else tmr <= tmr - 1'b1;
        ENG_XFER: if (tmr == '0) begin
          for (int b = 0; b < PAGE_BYTES; b++)
            pbuf_q[sel_q][b] <= main_q[page_q][b];
          tmr   <= TMR_W'(PROG_CYC - 1);
          state <= ENG_PROG;
        end else tmr <= tmr - 1'b1;
        ENG_PROG: if (tmr == '0) begin
          for (int b = 0; b < PAGE_BYTES; b++)
            main_q[page_q][b] <= pbuf_q[sel_q][b];
          state <= ENG_IDLE;
        end else tmr <= tmr - 1'b1;
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign busy_o = (state != ENG_IDLE);
  assign mism_o = mism_q;

  p_start_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && launch_i && is_arr) |=> busy_o);
  p_ignore_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && launch_i) |=> ($stable(page_q) && $stable(sel_q)));
  p_flag_cmp_only_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mism_q) |-> $past(state == ENG_CMP));
  p_rw_chain_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ENG_XFER && tmr == '0) |=> (state == ENG_PROG));
  p_busy_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(tmr == '0));
endmodule

// File: rtl/pagebuf_cmd_engine.sv
module pagebuf_cmd_engine
  import fce_pkg::*;
#(
  parameter int PAGES      = 16,
  parameter int PAGE_BYTES = 8,
  parameter int CMP_CYC    = 200,
  parameter int XFER_CYC   = 300,
  parameter int PROG_CYC   = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  output logic so_o,
  output logic rdy_o
);
  logic                 sck_fall, op_done, launch, busy, mism, stat_act;
  logic [7:0]           op, stat;
  logic [ADDR_BITS-1:0] addr;

  fce_spi_rx u_rx (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .si_i,
    .sck_fall_o(sck_fall), .op_done_o(op_done), .op_o(op),
    .launch_o(launch), .addr_o(addr)
  );

  fce_engine #(
    .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES),
    .CMP_CYC(CMP_CYC), .XFER_CYC(XFER_CYC), .PROG_CYC(PROG_CYC)
  ) u_eng (
    .clk_i, .rst_ni, .launch_i(launch), .op_i(op), .addr_i(addr),
    .busy_o(busy), .mism_o(mism)
  );

  assign stat     = {~busy, mism, 6'b0};
  assign stat_act = op_done && (op == OP_STAT);

  fce_stat_tx u_tx (
    .clk_i, .rst_ni, .active_i(stat_act), .fall_i(sck_fall),
    .stat_i(stat), .so_o
  );

  assign rdy_o = ~busy;

  p_rdy_launch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_o) |-> $past(launch));
endmodule

// File: tb/sim_pagebuf_cmd_engine.sv
module sim_pagebuf_cmd_engine;
  localparam int H = 6;
  localparam int CMP_CYC = 200, XFER_CYC = 300, PROG_CYC = 1000;

  logic clk = 1'b0, rst_ni = 1'b0, cs_ni = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, rdy;
  int n_chk = 0, n_fail = 0, busy_cnt = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$], got_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  pagebuf_cmd_engine u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck), .si_i(si),
    .so_o(so), .rdy_o(rdy)
  );

  always @(negedge clk) if (!rdy) busy_cnt <= busy_cnt + 1;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    wait (got_q.size() != 0);
    chk(tag_q.pop_front(), int'(got_q.pop_front()), int'(exp_q.pop_front()));
  end

  task automatic xbit(input logic b, output logic o);
    @(negedge clk); si = b;
    repeat (H) @(negedge clk);
    o = so; sck = 1'b1;
    repeat (H) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic sel_lo(); @(negedge clk); cs_ni = 1'b0; repeat (H) @(negedge clk); endtask
  task automatic sel_hi(); repeat (H) @(negedge clk); cs_ni = 1'b1; repeat (2*H) @(negedge clk); endtask

  task automatic frame(input logic [7:0] op, input logic [23:0] adr, input int nbits, input bit hold);
    logic [31:0] f = {op, adr};
    logic o;
    sel_lo();
    for (int i = 0; i < nbits; i++) xbit(f[31-i], o);
    if (!hold) sel_hi();
  endtask

  // driver: pushes expected status bytes, then reads them
  task automatic expect_stat(input logic [7:0] exp, input string tag, input int nb);
    logic o;
    logic [7:0] v;
    for (int k = 0; k < nb; k++) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    sel_lo();
    for (int i = 0; i < 8; i++) xbit(8'hD7 >> (7-i), o);
    for (int k = 0; k < nb; k++) begin
      for (int i = 0; i < 8; i++) begin xbit(1'b0, o); v[7-i] = o; end
      got_q.push_back(v);
    end
    sel_hi();
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin @(negedge clk); if (rdy) break; end
  endtask

  function automatic logic [23:0] pa(input int p, input logic [10:0] junk);
    return {13'(p), junk};
  endfunction

  task automatic run(input logic [7:0] op, input int p, input logic [10:0] junk);
    @(negedge clk); busy_cnt = 0;
    frame(op, pa(p, junk), 32, 1'b0);
    wait_idle();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 rdy after reset", int'(rdy), 1);
    expect_stat(8'h80, "R1 reset status", 1);

    // R4/R11: buffer 1 is zero, page 3 is not
    run(8'h60, 3, 11'h000);
    chk("R4 compare busy cycles", busy_cnt, CMP_CYC);
    expect_stat(8'hC0, "R4 mismatch b1", 1);

    run(8'h58, 3, 11'h000);
    chk("R5 rewrite busy cycles", busy_cnt, XFER_CYC + PROG_CYC);
    expect_stat(8'hC0, "R10 rewrite keeps bit6", 1);
    run(8'h60, 3, 11'h000);
    expect_stat(8'h80, "R5 page in b1 matches", 1);
    run(8'h60, 4, 11'h000);
    expect_stat(8'hC0, "R4 other page mismatch", 1);
    run(8'h60, 19, 11'h5A3);
    expect_stat(8'h80, "R2 page alias and dont-care", 1);

    run(8'h61, 3, 11'h000);
    expect_stat(8'hC0, "R4 b2 mismatch", 1);
    run(8'h59, 3, 11'h000);
    run(8'h61, 3, 11'h000);
    expect_stat(8'h80, "R5 b2 match", 1);
    run(8'h61, 4, 11'h000);
    expect_stat(8'hC0, "R4 b2 other page", 1);

    // R3: complete frame held, no start until select rises
    frame(8'h60, pa(3, 0), 32, 1'b1);
    repeat (30) @(negedge clk);
    chk("R3 no start while cs low", int'(rdy), 1);
    busy_cnt = 0;
    sel_hi();
    chk("R3 start after cs rise", int'(rdy), 0);
    wait_idle();
    expect_stat(8'h80, "R3 compare ran", 1);

    // R9: unknown opcode and short frame
    run(8'h61, 4, 11'h000);
    run(8'h55, 3, 11'h000);
    chk("R9 unknown op busy", busy_cnt, 0);
    @(negedge clk); busy_cnt = 0;
    frame(8'h61, pa(3, 0), 31, 1'b0);
    wait_idle();
    chk("R9 short frame busy", busy_cnt, 0);
    expect_stat(8'hC0, "R9 status unchanged", 1);

    // R6/R7/R8: commands during a rewrite
    @(negedge clk); busy_cnt = 0;
    frame(8'h58, pa(5, 0), 32, 1'b0);
    chk("R6 rdy low during rewrite", int'(rdy), 0);
    expect_stat(8'h40, "R6 R8 busy status two bytes", 2);
    frame(8'h61, pa(3, 0), 32, 1'b0);
    frame(8'h59, pa(7, 0), 32, 1'b0);
    chk("R7 still in first op", int'(rdy), 0);
    wait_idle();
    chk("R7 busy not stretched", busy_cnt, XFER_CYC + PROG_CYC);
    expect_stat(8'hC0, "R7 bit6 untouched", 1);
    run(8'h61, 3, 11'h000);
    expect_stat(8'h80, "R7 b2 not overwritten", 1);
    run(8'h60, 5, 11'h000);
    expect_stat(8'h80, "R5 page5 in b1", 1);
    chk("R8 so idle low", int'(so), 0);

    for (int i = 0; i < 100 && got_q.size() != 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule